// File: doc/BRIEF.md
# Stepper Feed Motor Phase Sequencer

This block turns a paper-feed request into coil drive for a four-coil hybrid stepping motor. A request carries a step count, in half-steps of 1/432 inch, and a flag that says whether a pull tractor is fitted. On acceptance the block latches one of three speed classes. It then advances the coils open-loop, one half-step per step period, through an eight-state pattern. In that pattern one coil and two adjacent coils take turns being energised. Between feeds it holds the rotor with a single energised coil.

The step period of each speed class is a whole number of clock cycles, taken from the clock frequency and the class's pulse rate. A direction input sets the way the pattern is walked, and it is sampled at every step. A small supervisor counts steps taken while coil A stays unchanged. If that count reaches the limit during a feed, it raises a reset request that stays set until reset.

Top module: `feed_step_seq`

## Requirements
- R1: Coil bits are bit0=A, bit1=B, bit2=C, bit3=D, and 1 energises a coil. During a feed the output for position p (0..7) is A, AB, B, BC, C, CD, D, DA (0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001).
- R2: Each step moves the position by +1 mod 8 when `dir_rev`=0 and by -1 mod 8 when `dir_rev`=1, with `dir_rev` sampled at that step.
- R3: When not busy, exactly one coil is on: the lower coil of the current position, 0001 << (p/2). It stays unchanged until the next accepted request.
- R4: A request with length ≤ 20 and `tractor`=0 selects the micro class, `mode`=0.
- R5: A request with length 21..60, or any request with `tractor`=1, selects the middle class, `mode`=1, at 2610 steps/s.
- R6: A request with length > 60 and `tractor`=0 selects the normal class, `mode`=2, at 4274 steps/s.
- R7: The step period is CLK_HZ/rate cycles (micro rate 1000/s). The first step shows at the outputs one period after `busy` rises.
- R8: `busy` rises the cycle after acceptance and falls with the last of the `feed_len` steps. `done` is high for exactly that one cycle.
- R9: A request while `busy`, or with length 0, is ignored: no step, and `mode` and the coils are unchanged.
- R10: If 16 steps pass during a feed with no change on coil A, `reset_req` rises and stays high until reset. A normal feed never raises it.
- R11: After reset: coils 0001, `busy`=0, `done`=0, `mode`=0, `reset_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feed_req | input | 1 | Feed request strobe |
| feed_len | input | LEN_W | Number of half-steps to take |
| tractor | input | 1 | Pull tractor fitted |
| dir_rev | input | 1 | 1 walks the pattern backwards |
| coil | output | 4 | Coil drive, bit0=A .. bit3=D |
| busy | output | 1 | Feed in progress |
| done | output | 1 | One-cycle pulse with the last step |
| mode | output | 2 | Latched speed class |
| reset_req | output | 1 | Sticky supervisor reset request |

## Verification
A corrupted position register shows up on `coil` at the next step edge, as a pattern that is not adjacent to the previous one. A wrong remaining-step count moves the `done` pulse and the fall of `busy` by whole step periods. A wrong divider or speed class shifts every later step, so the first scheduled step already lands on the wrong cycle. A supervisor that counts wrongly is exposed within 16 step periods, either by a late trip during a back-and-forth feed or by a false trip during a plain one.

// File: rtl/feed_seq_pkg.sv
package feed_seq_pkg;

  typedef enum logic [1:0] {
    MODE_MICRO = 2'd0,
    MODE_MID   = 2'd1,
    MODE_NORM  = 2'd2
  } feed_mode_e;

  // Speed class from length (half-steps) and tractor flag; boundaries go low.
  function automatic feed_mode_e pick_mode(input int unsigned len, input logic tractor,
                                           input int unsigned micro_max,
                                           input int unsigned mid_max);
    if (!tractor && len <= micro_max) return MODE_MICRO;
    if (tractor || len <= mid_max)    return MODE_MID;
    return MODE_NORM;
  endfunction

  // Half-step drive: even positions one coil, odd positions that coil plus the next.
  function automatic logic [3:0] coil_drive(input logic [2:0] pos);
    logic [3:0] lo;
    lo = 4'b0001 << pos[2:1];
    return pos[0] ? (lo | {lo[2:0], lo[3]}) : lo;
  endfunction

  // Holding: lower coil of the current position only.
  function automatic logic [3:0] coil_hold(input logic [2:0] pos);
    return 4'b0001 << pos[2:1];
  endfunction

  function automatic int unsigned step_div(input int unsigned clk_hz, input int unsigned pps);
    return clk_hz / pps;
  endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int unsigned CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] period,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/coil_sequencer.sv
module coil_sequencer
  import feed_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       dir_rev,
  input  logic       drive,
  output logic [3:0] coil,
  output logic [2:0] pos
);
  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= 3'd0;
    else if (step) pos <= dir_rev ? pos - 3'd1 : pos + 3'd1;
  end

  always_comb coil = drive ? coil_drive(pos) : coil_hold(pos);
endmodule

// File: rtl/phase_watchdog.sv
module phase_watchdog #(
  parameter int unsigned WD_STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic step,
  input  logic coil_a,
  output logic trip
);
  localparam int unsigned WW = $clog2(WD_STEPS + 1);

  logic [WW-1:0] quiet;
  logic          a_q;
  logic          a_edge;

  assign a_edge = coil_a ^ a_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet <= '0;
      a_q   <= 1'b1;
      trip  <= 1'b0;
    end else begin
      a_q <= coil_a;
      if (!active || a_edge) begin
        quiet <= '0;
      end else if (step) begin
        if (quiet == WW'(WD_STEPS - 1)) begin
          trip  <= 1'b1;
          quiet <= '0;
        end else begin
          quiet <= quiet + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/feed_step_seq.sv
module feed_step_seq
  import feed_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned NORM_PPS  = 4274,
  parameter int unsigned MID_PPS   = 2610,
  parameter int unsigned MICRO_PPS = 1000,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned MICRO_MAX = 20,
  parameter int unsigned MID_MAX   = 60,
  parameter int unsigned WD_STEPS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feed_req,
  input  logic [LEN_W-1:0] feed_len,
  input  logic             tractor,
  input  logic             dir_rev,
  output logic [3:0]       coil,
  output logic             busy,
  output logic             done,
  output logic [1:0]       mode,
  output logic             reset_req
);
  localparam int unsigned NORM_DIV  = step_div(CLK_HZ, NORM_PPS);
  localparam int unsigned MID_DIV   = step_div(CLK_HZ, MID_PPS);
  localparam int unsigned MICRO_DIV = step_div(CLK_HZ, MICRO_PPS);
  localparam int unsigned DIV_HI    = (NORM_DIV > MID_DIV) ? NORM_DIV : MID_DIV;
  localparam int unsigned DIV_MAX   = (DIV_HI > MICRO_DIV) ? DIV_HI : MICRO_DIV;
  localparam int unsigned CW        = $clog2(DIV_MAX + 1);

  feed_mode_e       sel_mode;
  feed_mode_e       mode_q;
  logic [LEN_W-1:0] remain;
  logic [CW-1:0]    period;
  logic             accept;
  logic             step;
  logic             last_step;
  logic [2:0]       pos;

  assign sel_mode  = pick_mode(32'(feed_len), tractor, MICRO_MAX, MID_MAX);
  assign accept    = feed_req && !busy && (feed_len != '0);
  assign last_step = step && (remain == LEN_W'(1));
  assign mode      = mode_q;

  always_comb begin
    case (mode_q)
      MODE_NORM: period = CW'(NORM_DIV);
      MODE_MID:  period = CW'(MID_DIV);
      default:   period = CW'(MICRO_DIV);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
      mode_q <= MODE_MICRO;
    end else begin
      done <= last_step;
      if (accept) begin
        busy   <= 1'b1;
        remain <= feed_len;
        mode_q <= sel_mode;
      end else if (step) begin
        remain <= remain - 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

  step_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .period(period), .tick(step)
  );

  coil_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .dir_rev(dir_rev),
    .drive(busy), .coil(coil), .pos(pos)
  );

  phase_watchdog #(.WD_STEPS(WD_STEPS)) u_wd (
    .clk(clk), .rst_n(rst_n), .active(busy), .step(step),
    .coil_a(coil[0]), .trip(reset_req)
  );
endmodule

// File: rtl/feed_step_seq_chk.sv
module feed_step_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       reset_req,
  input logic [3:0] coil,
  input logic [1:0] mode,
  input logic       step,
  input logic [2:0] pos
);
  assert_drive_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(coil) == 1 || $countones(coil) == 2));

  assert_step_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pos == $past(pos) + 3'd1 || pos == $past(pos) - 3'd1));

  assert_hold_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ($countones(coil) == 1));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || $stable(coil)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_mode_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(mode)));

  assert_trip_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);

  assert_trip_in_feed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(busy));
endmodule

bind feed_step_seq feed_step_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .reset_req(reset_req),
  .coil(coil), .mode(mode), .step(step), .pos(pos)
);

// File: tb/feed_step_seq_tb_top.sv
`timescale 1ns/1ps
module feed_step_seq_tb_top;
  localparam int unsigned CLK_HZ = 100_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       feed_req = 1'b0;
  logic [7:0] feed_len = 8'd0;
  logic       tractor = 1'b0;
  logic       dir_rev = 1'b0;
  logic [3:0] coil;
  logic       busy, done, reset_req;
  logic [1:0] mode;

  always #2.5 clk = ~clk;

  feed_step_seq #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .feed_req(feed_req), .feed_len(feed_len),
    .tractor(tractor), .dir_rev(dir_rev), .coil(coil), .busy(busy),
    .done(done), .mode(mode), .reset_req(reset_req)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int unsigned at;
    logic [3:0]  coil;
    logic        busy;
    logic        done;
    logic [1:0]  mode;
    string       ctag;
    string       mtag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails = 0;
  bit   finished = 0;
  int   model_pos = 0;
  logic [3:0] ring [8] = '{4'b0001, 4'b0011, 4'b0010, 4'b0110,
                           4'b0100, 4'b1100, 4'b1000, 4'b1001};

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // Monitor: pop scheduled expectations on their cycle.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].at == cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(coil == e.coil, e.ctag, "coil", coil, e.coil);
      chk(busy == e.busy, "R8", "busy", busy, e.busy);
      chk(done == e.done, "R8", "done", done, e.done);
      chk(mode == e.mode, e.mtag, "mode", mode, e.mode);
    end
  end

  function automatic int exp_mode(int len, bit tr);
    if (tr) return 1;
    if (len > 60) return 2;
    if (len > 20) return 1;
    return 0;
  endfunction

  function automatic int exp_div(int m);
    case (m)
      2: return CLK_HZ / 4274;
      1: return CLK_HZ / 2610;
      default: return CLK_HZ / 1000;
    endcase
  endfunction

  // Driver: schedule every expected output, then issue the request.
  task automatic feed(int len, bit tr, bit rev, bit poke);
    int m;
    int d;
    int unsigned c;
    logic [3:0] prev;
    string mt;
    string ct;
    m  = exp_mode(len, tr);
    d  = exp_div(m);
    mt = (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
    @(negedge clk);
    c = cyc;
    prev = ring[model_pos];
    sb.push_back('{c + 1, prev, 1'b1, 1'b0, m[1:0], "R1", mt});
    for (int k = 1; k <= len; k++) begin
      sb.push_back('{c + k * d, prev, 1'b1, 1'b0, m[1:0], "R7", mt});
      model_pos = rev ? (model_pos + 7) % 8 : (model_pos + 1) % 8;
      if (k == len) begin
        prev = ring[model_pos & 6];
        ct = "R3";
      end else begin
        prev = ring[model_pos];
        ct = "R2";
      end
      sb.push_back('{c + 1 + k * d, prev, (k < len), (k == len), m[1:0], ct, mt});
    end
    feed_len = len[7:0];
    tractor  = tr;
    dir_rev  = rev;
    feed_req = 1'b1;
    @(negedge clk);
    feed_req = 1'b0;
    if (poke) begin
      // R9: request during a feed must change nothing
      repeat (d + 3) @(negedge clk);
      feed_req = 1'b1;
      feed_len = 8'd5;
      tractor  = ~tr;
      @(negedge clk);
      feed_req = 1'b0;
    end
    wait (sb.size() == 0);
    @(negedge clk);
    chk(reset_req == 1'b0, "R10", "no trip on plain feed", reset_req, 0);
  endtask

  initial begin
    logic [3:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(coil == 4'b0001, "R11", "reset coil", coil, 1);
    chk(busy == 1'b0, "R11", "reset busy", busy, 0);
    chk(done == 1'b0, "R11", "reset done", done, 0);
    chk(mode == 2'd0, "R11", "reset mode", mode, 0);
    chk(reset_req == 1'b0, "R11", "reset trip", reset_req, 0);

    feed(10, 1'b0, 1'b0, 1'b0);   // R4 micro
    feed(20, 1'b0, 1'b0, 1'b1);   // R4 boundary, R9 poke
    feed(21, 1'b0, 1'b0, 1'b0);   // R5, ends on odd position (R3 hold)
    feed(60, 1'b0, 1'b0, 1'b0);   // R5 boundary
    feed(61, 1'b0, 1'b0, 1'b0);   // R6
    feed(61, 1'b0, 1'b1, 1'b0);   // R6 reverse, R2
    feed(15, 1'b1, 1'b0, 1'b0);   // R5 tractor short
    feed(100, 1'b1, 1'b1, 1'b1);  // R5 tractor long, reverse, R9 poke

    // R9: zero-length request ignored
    held = coil;
    @(negedge clk);
    feed_len = 8'd0; feed_req = 1'b1;
    @(negedge clk);
    feed_req = 1'b0;
    chk(busy == 1'b0, "R9", "zero length busy", busy, 0);
    repeat (50) @(negedge clk);
    chk(coil == held, "R9", "zero length coil", coil, held);
    chk(busy == 1'b0 && done == 1'b0, "R9", "zero length idle", {busy, done}, 0);

    // R10: rock between positions 0 and 1, coil A never changes
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    dir_rev = 1'b0; tractor = 1'b0; feed_len = 8'd20; feed_req = 1'b1;
    @(negedge clk);
    feed_req = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      logic [3:0] ex;
      repeat (100) @(negedge clk);
      ex = (k % 2 == 1) ? 4'b0011 : 4'b0001;
      chk(coil == ex, "R2", "rocking coil", coil, ex);
      dir_rev = ~dir_rev;
      if (k == 15) chk(reset_req == 1'b0, "R10", "trip before limit", reset_req, 0);
      if (k == 17) chk(reset_req == 1'b1, "R10", "trip after limit", reset_req, 1);
    end
    chk(done == 1'b1, "R8", "rocking done", done, 1);
    chk(reset_req == 1'b1, "R10", "trip sticky", reset_req, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule